// File: doc/BRIEF.md
# Shift-and-Add Constant Multiplier with Scaled Division

This block multiplies a stream of signed samples by a coefficient fixed at elaboration time. No general multiplier is used. The coefficient is rewritten into minimal signed-digit form, with digits drawn from {-1, 0, +1} and no two non-zero digits next to each other. The datapath is a chain of shifted copies of the sample. A digit of zero costs nothing. The first non-zero digit only loads its shifted copy. Each further non-zero digit adds one adder or one subtractor. A run of ones such as 15 therefore costs a single subtraction: (x<<4) - x.

The same structure also approximates division by a constant D. The integrator works out a pair (X, k) with X/2^k close to 1/D. The block is then built with coefficient X and shift k. The product goes through an arithmetic right shift of k bits, which rounds toward negative infinity. For example, dividing by 9 uses X = 7 and k = 6. Here 7 is built as (x<<3) - x, which is one subtractor.

Samples enter and results leave on valid/ready streams. A result is registered once, so it appears one cycle after its sample is accepted. Back-pressure follows these rules:
- While `out_valid` is high and `out_ready` is low, the result is held unchanged.
- `in_ready` is high whenever the output register is empty or is being drained in the same cycle.

Top module: `csd_const_mul`

## Requirements
- R1: With SHIFT_K = 0, every result equals the exact signed product in_data × COEF, for any signed in_data and any signed COEF that fits in COEF_W bits.
- R2: With SHIFT_K = k > 0, every result equals floor(in_data × COEF / 2^k), an arithmetic right shift rounded toward negative infinity (for example COEF = 7, k = 6 approximates division by 9).
- R3: A sample accepted in cycle n (in_valid and in_ready both high at that clock edge) appears on out_data with out_valid high after that same edge, i.e. one cycle of latency.
- R4: While out_valid is high and out_ready is low, out_valid stays high and out_data keeps its value at the next edge.
- R5: in_ready is high exactly when out_valid is low or out_ready is high; a sample is taken only when in_valid and in_ready are both high.
- R6: During reset and in the first cycle after it, out_valid is low and in_ready is high.
- R7: With COEF = 0 every result is zero, whatever the sample.
- R8: Extreme samples (most negative and most positive) combined with the most negative coefficient produce the exact product, with no overflow, in OUT_W = IN_W + COEF_W bits.
- R9: When the held result is taken (out_ready high) and no new sample is offered, out_valid is low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Block can take a sample this cycle |
| in_data | input | IN_W | Signed input sample |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Downstream takes the result |
| out_data | output | OUT_W | Signed result, product or scaled product |

## Verification
The hardest case to reach is a stall that starts in the same cycle as a new sample is offered. Here the held result must survive, the incoming sample must be refused, and the sample must be taken later without being lost or duplicated. To get there, the stimulus runs phases with out_ready random and mostly low while in_valid stays high. The bench model decides acceptance from its own view of ready. Several builds run side by side on the same stream, with coefficients 7/k=6, 15, 0, 1, -13 and -128, and the stream injects extreme and sign-boundary samples. This brings out both the run-of-ones recoding and the rounding toward negative infinity of the shifted division.

// File: rtl/csd_mul_pkg.sv
package csd_mul_pkg;

  localparam int MAX_DIG = 33;

  typedef struct packed {
    logic [MAX_DIG-1:0] pos;
    logic [MAX_DIG-1:0] neg;
  } csd_t;

  typedef enum int {
    STG_PASS = 0,
    STG_ADD  = 1,
    STG_SUB  = 2,
    STG_LOADP = 3,
    STG_LOADN = 4
  } stage_kind_e;

  // Minimal signed-digit form: repeatedly strip the low digit so the
  // remainder is divisible by four, which keeps non-zero digits apart.
  function automatic csd_t csd_recode(longint coef);
    longint v;
    csd_t   r;
    v = coef;
    r = '0;
    for (int i = 0; i < MAX_DIG; i++) begin
      if (v[0]) begin
        if (!v[1]) begin
          r.pos[i] = 1'b1;
          v = v - 1;
        end else begin
          r.neg[i] = 1'b1;
          v = v + 1;
        end
      end
      v = v >>> 1;
    end
    return r;
  endfunction

  function automatic int csd_first(csd_t r);
    int idx;
    idx = MAX_DIG;
    for (int i = MAX_DIG - 1; i >= 0; i--) begin
      if (r.pos[i] || r.neg[i]) idx = i;
    end
    return idx;
  endfunction

  function automatic int csd_nonzero(csd_t r);
    int n;
    n = 0;
    for (int i = 0; i < MAX_DIG; i++) begin
      if (r.pos[i] || r.neg[i]) n++;
    end
    return n;
  endfunction

  function automatic stage_kind_e csd_kind(csd_t r, int idx);
    stage_kind_e k;
    k = STG_PASS;
    if (idx == csd_first(r)) begin
      if (r.pos[idx]) k = STG_LOADP;
      else if (r.neg[idx]) k = STG_LOADN;
    end else if (r.pos[idx]) begin
      k = STG_ADD;
    end else if (r.neg[idx]) begin
      k = STG_SUB;
    end
    return k;
  endfunction

endpackage

// File: rtl/csd_digit_stage.sv
module csd_digit_stage
  import csd_mul_pkg::*;
#(
  parameter int          W     = 24,
  parameter int          SHIFT = 0,
  parameter stage_kind_e KIND  = STG_PASS
) (
  input  logic signed [W-1:0] acc_i,
  input  logic signed [W-1:0] x_i,
  output logic signed [W-1:0] acc_o
);

  logic signed [W-1:0] term;
  assign term = x_i <<< SHIFT;

  generate
    if (KIND == STG_ADD) begin : g_add
      assign acc_o = acc_i + term;
    end else if (KIND == STG_SUB) begin : g_sub
      assign acc_o = acc_i - term;
    end else if (KIND == STG_LOADP) begin : g_loadp
      logic signed [W-1:0] unused_acc;
      assign unused_acc = acc_i;
      assign acc_o = term;
    end else if (KIND == STG_LOADN) begin : g_loadn
      logic signed [W-1:0] unused_acc;
      assign unused_acc = acc_i;
      assign acc_o = -term;
    end else begin : g_pass
      logic signed [W-1:0] unused_term;
      assign unused_term = term;
      assign acc_o = acc_i;
    end
  endgenerate

endmodule

// File: rtl/csd_scale.sv
module csd_scale #(
  parameter int W = 24,
  parameter int K = 0
) (
  input  logic signed [W-1:0] prod_i,
  output logic signed [W-1:0] res_o
);

  generate
    if (K == 0) begin : g_none
      assign res_o = prod_i;
    end else begin : g_shift
      assign res_o = prod_i >>> K;
    end
  endgenerate

endmodule

// File: rtl/csd_out_reg.sv
module csd_out_reg #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         d_valid,
  output logic         d_ready,
  input  logic [W-1:0] d_data,
  output logic         q_valid,
  input  logic         q_ready,
  output logic [W-1:0] q_data
);

  logic take;

  assign d_ready = !q_valid || q_ready;
  assign take    = d_valid && d_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
    end else if (d_ready) begin
      q_valid <= d_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_data <= '0;
    end else if (take) begin
      q_data <= d_data;
    end
  end

endmodule

// File: rtl/csd_const_mul.sv
module csd_const_mul
  import csd_mul_pkg::*;
#(
  parameter int IN_W    = 16,
  parameter int COEF_W  = 8,
  parameter int COEF    = 7,
  parameter int SHIFT_K = 6,
  parameter int OUT_W   = IN_W + COEF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IN_W-1:0]  in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OUT_W-1:0] out_data
);

  localparam csd_t RECODE = csd_recode(longint'(COEF));
  localparam int   DIGITS = COEF_W + 1;
  localparam int   NZ     = csd_nonzero(RECODE);

  logic signed [OUT_W-1:0] x_ext;
  logic signed [OUT_W-1:0] chain [DIGITS+1];
  logic signed [OUT_W-1:0] scaled;

  assign x_ext    = OUT_W'($signed(in_data));
  assign chain[0] = '0;

  generate
    for (genvar g = 0; g < DIGITS; g++) begin : g_dig
      csd_digit_stage #(
        .W    (OUT_W),
        .SHIFT(g),
        .KIND (csd_kind(RECODE, g))
      ) u_stage (
        .acc_i(chain[g]),
        .x_i  (x_ext),
        .acc_o(chain[g+1])
      );
    end
  endgenerate

  csd_scale #(
    .W(OUT_W),
    .K(SHIFT_K)
  ) u_scale (
    .prod_i(chain[DIGITS]),
    .res_o (scaled)
  );

  csd_out_reg #(
    .W(OUT_W)
  ) u_oreg (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_valid(in_valid),
    .d_ready(in_ready),
    .d_data (scaled),
    .q_valid(out_valid),
    .q_ready(out_ready),
    .q_data (out_data)
  );

  initial begin
    if (NZ > DIGITS) $display("csd_const_mul: coefficient does not fit");
  end

endmodule

// File: rtl/csd_const_mul_chk.sv
module csd_const_mul_chk #(
  parameter int IN_W    = 16,
  parameter int COEF_W  = 8,
  parameter int COEF    = 7,
  parameter int SHIFT_K = 6,
  parameter int OUT_W   = IN_W + COEF_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [IN_W-1:0]  in_data,
  input logic             out_valid,
  input logic             out_ready,
  input logic [OUT_W-1:0] out_data
);

  function automatic logic [OUT_W-1:0] ref_val(logic [IN_W-1:0] x);
    longint p;
    p = longint'($signed(x)) * longint'(COEF);
    p = p >>> SHIFT_K;
    return OUT_W'(p);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      a_r6_idle_in_reset: assert (!out_valid && in_ready);
    end
  end

  a_r4_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  a_r3_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  a_r1_value: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_data == ref_val($past(in_data)));

  a_r9_drain: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !in_valid |=> !out_valid);

  a_r5_accept_when_free: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

endmodule

bind csd_const_mul csd_const_mul_chk #(
  .IN_W   (IN_W),
  .COEF_W (COEF_W),
  .COEF   (COEF),
  .SHIFT_K(SHIFT_K),
  .OUT_W  (OUT_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_data  (in_data),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_data (out_data)
);

// File: tb/csd_const_mul_tb.sv
module csd_const_mul_tb;

  localparam int IN_W  = 16;
  localparam int CW    = 8;
  localparam int OW    = IN_W + CW;
  localparam int NDUT  = 6;

  localparam int COEFS  [NDUT] = '{7, 15, 0, 1, -13, -128};
  localparam int SHIFTS [NDUT] = '{6, 0, 0, 0, 0, 0};

  logic clk = 0;
  logic rst_n = 0;
  logic in_valid = 0;
  logic out_ready = 0;
  logic [IN_W-1:0] in_data = '0;
  logic [NDUT-1:0] rdy;
  logic [NDUT-1:0] ov;
  logic [OW-1:0] od [NDUT];

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  csd_const_mul #(.IN_W(IN_W), .COEF_W(CW), .COEF(7), .SHIFT_K(6)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy[0]), .in_data(in_data),
    .out_valid(ov[0]), .out_ready(out_ready), .out_data(od[0]));
  csd_const_mul #(.IN_W(IN_W), .COEF_W(CW), .COEF(15), .SHIFT_K(0)) u_c15 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy[1]), .in_data(in_data),
    .out_valid(ov[1]), .out_ready(out_ready), .out_data(od[1]));
  csd_const_mul #(.IN_W(IN_W), .COEF_W(CW), .COEF(0), .SHIFT_K(0)) u_c0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy[2]), .in_data(in_data),
    .out_valid(ov[2]), .out_ready(out_ready), .out_data(od[2]));
  csd_const_mul #(.IN_W(IN_W), .COEF_W(CW), .COEF(1), .SHIFT_K(0)) u_c1 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy[3]), .in_data(in_data),
    .out_valid(ov[3]), .out_ready(out_ready), .out_data(od[3]));
  csd_const_mul #(.IN_W(IN_W), .COEF_W(CW), .COEF(-13), .SHIFT_K(0)) u_cn13 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy[4]), .in_data(in_data),
    .out_valid(ov[4]), .out_ready(out_ready), .out_data(od[4]));
  csd_const_mul #(.IN_W(IN_W), .COEF_W(CW), .COEF(-128), .SHIFT_K(0)) u_cmin (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy[5]), .in_data(in_data),
    .out_valid(ov[5]), .out_ready(out_ready), .out_data(od[5]));

  // Behavioural reference: one queue per build, depth at most one.
  longint exp_q [NDUT][$];
  logic   exp_valid;
  logic   exp_ready;

  assign exp_ready = !exp_valid || out_ready;

  function automatic longint ref_result(int idx, logic [IN_W-1:0] x);
    longint p;
    p = longint'($signed(x)) * longint'(COEFS[idx]);
    for (int s = 0; s < SHIFTS[idx]; s++) begin
      p = (p < 0 && (p % 2 != 0)) ? (p - 1) / 2 : p / 2;
    end
    return p;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_valid <= 1'b0;
      for (int i = 0; i < NDUT; i++) exp_q[i].delete();
    end else if (exp_ready) begin
      for (int i = 0; i < NDUT; i++) begin
        if (exp_q[i].size() > 0) void'(exp_q[i].pop_front());
        if (in_valid) exp_q[i].push_back(ref_result(i, in_data));
      end
      exp_valid <= in_valid;
    end
  end

  function automatic string req_of(int idx, logic [IN_W-1:0] x);
    if (idx == 0) return "R2";
    if (idx == 2) return "R7";
    if (idx == 5 && (x == 16'h8000 || x == 16'h7fff)) return "R8";
    return "R1";
  endfunction

  logic [IN_W-1:0] last_acc [$];

  task automatic check_cycle();
    for (int i = 0; i < NDUT; i++) begin
      checks++;
      if (ov[i] !== exp_valid) begin
        errors++;
        $display("FAIL R3/R9 dut%0d out_valid actual %0b expected %0b", i, ov[i], exp_valid);
      end
      checks++;
      if (rdy[i] !== exp_ready) begin
        errors++;
        $display("FAIL R5 dut%0d in_ready actual %0b expected %0b", i, rdy[i], exp_ready);
      end
      if (exp_valid && exp_q[i].size() > 0) begin
        checks++;
        if ($signed(od[i]) != exp_q[i][0]) begin
          errors++;
          $display("FAIL %s dut%0d out_data actual %0d expected %0d",
                   req_of(i, last_acc.size() > 0 ? last_acc[$] : '0), i,
                   $signed(od[i]), exp_q[i][0]);
        end
      end
    end
  endtask

  // Track the sample accepted last, for labelling only.
  always @(posedge clk) begin
    if (rst_n && in_valid && exp_ready) begin
      last_acc.push_back(in_data);
      if (last_acc.size() > 4) void'(last_acc.pop_front());
    end
  end

  function automatic logic [IN_W-1:0] pick_sample(int n);
    case (n % 9)
      0: return 16'h8000;
      1: return 16'h7fff;
      2: return 16'hffff;
      3: return 16'h0001;
      4: return 16'h0000;
      5: return 16'hfff7;
      default: return IN_W'($urandom);
    endcase
  endfunction

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    // R6: reset state
    for (int i = 0; i < NDUT; i++) begin
      checks++;
      if (ov[i] !== 1'b0 || rdy[i] !== 1'b1) begin
        errors++;
        $display("FAIL R6 dut%0d valid/ready actual %0b/%0b expected 0/1", i, ov[i], rdy[i]);
      end
    end
    rst_n = 1;
    @(negedge clk);
    for (int i = 0; i < NDUT; i++) begin
      checks++;
      if (ov[i] !== 1'b0) begin
        errors++;
        $display("FAIL R6 dut%0d out_valid after reset actual %0b expected 0", i, ov[i]);
      end
    end
    // Phase A: free flow (R1, R2, R3, R7, R8)
    // Phase B: random ready and valid (R4, R5)
    // Phase C: long stalls with valid held, then drain (R4, R9)
    for (int n = 0; n < 900; n++) begin
      check_cycle();
      if (n < 300) begin
        out_ready = 1'b1;
        in_valid  = 1'b1;
        in_data   = pick_sample(n);
      end else if (n < 600) begin
        out_ready = ($urandom % 3) != 0;
        if (!in_valid || exp_ready) begin
          in_valid = ($urandom % 4) != 0;
          in_data  = pick_sample(n);
        end
      end else begin
        out_ready = ($urandom % 5) == 0;
        if (!in_valid || exp_ready) begin
          in_valid = (n % 40) < 25;
          in_data  = pick_sample(n + 3);
        end
      end
      @(negedge clk);
    end
    // Final drain: R9
    in_valid  = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    check_cycle();
    @(negedge clk);
    check_cycle();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule